// File: doc/BRIEF.md
# Keyboard Controller Command Decoder

This block is the host side of a PC-style keyboard and mouse controller. The host writes single bytes to a command port and to a data port. A command byte either acts at once or arms a write target. Acting at once covers reading back controller state, setting or clearing interface-disable flags, moving the A20 gate and requesting a system reset. When a write target is armed, the next data-port byte goes to that target instead of to the keyboard. The block keeps the mode byte, the output port byte and the status byte. It produces reply bytes for a controller reply slot, and it sends device-bound bytes out on one-cycle valid/data strobes.

Every output is a register. A write sampled at clock edge k shows its full effect on the outputs directly after edge k. A reply byte, a device byte, the reset request and the error flag each appear as a one-cycle pulse. The controller does not reset itself when it issues a reset request. Resetting the system is left to the logic that receives the pulse.

Top module: `kbc_cmd_engine`

## Requirements
- R1: After reset, mode is 0x03, status is 0x18, output port is 0xCF, the A20 output is 1, translation enable is 0, and no strobe is high.
- R2: Command 0x20 replies with the mode byte, 0xD0 with the output port, 0xC0 with 0x80, and 0xA9 and 0xAB with 0x00. Each reply is a one-cycle rep_vld_o pulse with rep_aux_o = 0.
- R3: Command 0xAA sets status bit 2 and replies 0x55.
- R4: Commands 0xAD and 0xA7 set mode bit 4 (keyboard off) and mode bit 5 (mouse off). Commands 0xAE and 0xA8 clear those bits.
- R5: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a write target for the next data byte. A later arming command replaces the target. Other commands leave the target as it is. Any accepted data byte disarms the target.
- R6: An unarmed data byte is sent on the keyboard strobe and clears mode bit 4. A data byte under 0xD4 is sent on the mouse strobe and clears mode bit 5.
- R7: A data byte under 0x60 replaces the mode byte. Translation enable follows mode bit 6.
- R8: A data byte under 0xD2 is replied with rep_aux_o = 0. A data byte under 0xD3 is replied with rep_aux_o = 1.
- R9: A data byte under 0xD1 replaces the output port. The A20 output follows port bit 1. If port bit 0 is 0, sys_rst_o pulses for one cycle, and the block's own state is not reset.
- R10: Command 0xDD clears output port bit 1 and A20. Command 0xDF sets them.
- R11: A command with upper nibble 0xF pulses sys_rst_o when its bit 0 is 0. When bit 0 is 1 it changes nothing.
- R12: Any other command byte raises bad_cmd_o for one cycle and leaves mode, status, output port and the armed target unchanged.
- R13: When a command write and a data write occur in the same cycle, the command executes and the data byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_i | input | 1 | Command-port write strobe |
| cmd_byte_i | input | 8 | Command byte |
| dat_wr_i | input | 1 | Data-port write strobe |
| dat_byte_i | input | 8 | Data byte |
| rep_vld_o | output | 1 | Reply byte valid (one cycle) |
| rep_byte_o | output | 8 | Reply byte |
| rep_aux_o | output | 1 | Reply is tagged as mouse-sourced |
| kbd_tx_vld_o | output | 1 | Byte for the keyboard valid |
| kbd_tx_byte_o | output | 8 | Byte for the keyboard |
| aux_tx_vld_o | output | 1 | Byte for the mouse valid |
| aux_tx_byte_o | output | 8 | Byte for the mouse |
| mode_o | output | 8 | Mode byte |
| status_o | output | 8 | Status byte |
| outport_o | output | 8 | Output port byte |
| xlat_en_o | output | 1 | Scan-code translation enable |
| a20_o | output | 1 | A20 gate |
| sys_rst_o | output | 1 | System reset request pulse |
| bad_cmd_o | output | 1 | Unrecognised command pulse |

## Verification
The bench checks that an armed target survives both a non-arming command and an unrecognised command. A design that cleared the target on every command would send the later data byte to the keyboard. It also checks a reset request written through the output port: the pulse must last one cycle, and the new port value must stay in place. A design that reset itself would put 0xCF back, and a level-type request would stay high. Pulse-family bytes with bit 0 set must leave the state untouched, and a design that decoded them as unknown commands would raise the error flag. Writes to both ports in the same cycle must route nothing to the keyboard, so a data path that ignored the clash would produce a keyboard strobe in the same cycle as the reply.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  parameter int unsigned KBC_BW = 8;
  typedef logic [KBC_BW-1:0] kbc_byte_t;

  localparam int unsigned MODE_KBD_OFF  = 4;
  localparam int unsigned MODE_AUX_OFF  = 5;
  localparam int unsigned MODE_XLAT     = 6;
  localparam int unsigned STAT_SELFTEST = 2;
  localparam int unsigned PORT_NRST     = 0;
  localparam int unsigned PORT_A20      = 1;

  typedef enum logic [3:0] {
    OP_BAD, OP_NOP, OP_SYSRST, OP_RD_MODE, OP_RD_PORT, OP_REPLY_K,
    OP_SELFTEST, OP_ARM, OP_KBD_OFF, OP_KBD_ON, OP_AUX_OFF, OP_AUX_ON,
    OP_A20_OFF, OP_A20_ON
  } kbc_op_e;

  typedef enum logic [2:0] {
    PW_NONE, PW_MODE, PW_PORT, PW_KREP, PW_AREP, PW_AUX
  } kbc_pw_e;

  typedef struct packed {
    kbc_op_e   op;
    kbc_pw_e   arm;
    kbc_byte_t konst;
  } kbc_dec_t;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  kbc_byte_t cmd_i,
  output kbc_dec_t  dec_o
);
  always_comb begin
    dec_o       = '0;
    dec_o.op    = OP_BAD;
    dec_o.arm   = PW_NONE;
    dec_o.konst = '0;
    if (cmd_i[7:4] == 4'hF) begin
      dec_o.op = cmd_i[0] ? OP_NOP : OP_SYSRST;
    end else begin
      case (cmd_i)
        8'h20: dec_o.op = OP_RD_MODE;
        8'h60: begin dec_o.op = OP_ARM; dec_o.arm = PW_MODE; end
        8'hD1: begin dec_o.op = OP_ARM; dec_o.arm = PW_PORT; end
        8'hD2: begin dec_o.op = OP_ARM; dec_o.arm = PW_KREP; end
        8'hD3: begin dec_o.op = OP_ARM; dec_o.arm = PW_AREP; end
        8'hD4: begin dec_o.op = OP_ARM; dec_o.arm = PW_AUX;  end
        8'hA7: dec_o.op = OP_AUX_OFF;
        8'hA8: dec_o.op = OP_AUX_ON;
        8'hAD: dec_o.op = OP_KBD_OFF;
        8'hAE: dec_o.op = OP_KBD_ON;
        8'hA9, 8'hAB: begin dec_o.op = OP_REPLY_K; dec_o.konst = 8'h00; end
        8'hC0: begin dec_o.op = OP_REPLY_K; dec_o.konst = 8'h80; end
        8'hAA: begin dec_o.op = OP_SELFTEST; dec_o.konst = 8'h55; end
        8'hD0: dec_o.op = OP_RD_PORT;
        8'hDD: dec_o.op = OP_A20_OFF;
        8'hDF: dec_o.op = OP_A20_ON;
        default: dec_o.op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/kbc_outport.sv
module kbc_outport
  import kbc_pkg::*;
#(
  parameter kbc_byte_t RST_VAL = 8'hCF
)(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_i,
  input  kbc_byte_t wr_val_i,
  input  logic      a20_set_i,
  input  logic      a20_clr_i,
  input  logic      pulse_rst_i,
  output kbc_byte_t port_o,
  output logic      a20_o,
  output logic      sys_rst_o
);
  kbc_byte_t port_q;
  logic      rst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= RST_VAL;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= pulse_rst_i;
      if (wr_i) begin
        port_q <= wr_val_i;
        if (!wr_val_i[PORT_NRST]) rst_q <= 1'b1;
      end else if (a20_set_i) begin
        port_q[PORT_A20] <= 1'b1;
      end else if (a20_clr_i) begin
        port_q[PORT_A20] <= 1'b0;
      end
    end
  end

  assign port_o    = port_q;
  assign a20_o     = port_q[PORT_A20];
  assign sys_rst_o = rst_q;

  // R10
  a20_on_chk: assert property (@(posedge clk) disable iff (rst)
    (a20_set_i && !wr_i) |=> a20_o);
  // R9
  port_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !wr_val_i[PORT_NRST]) |=> (sys_rst_o && port_o == $past(wr_val_i)));
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
#(
  parameter kbc_byte_t MODE_RST = 8'h03,
  parameter kbc_byte_t STAT_RST = 8'h18,
  parameter kbc_byte_t PORT_RST = 8'hCF
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_wr_i,
  input  logic [7:0]      cmd_byte_i,
  input  logic            dat_wr_i,
  input  logic [7:0]      dat_byte_i,
  output logic            rep_vld_o,
  output logic [7:0]      rep_byte_o,
  output logic            rep_aux_o,
  output logic            kbd_tx_vld_o,
  output logic [7:0]      kbd_tx_byte_o,
  output logic            aux_tx_vld_o,
  output logic [7:0]      aux_tx_byte_o,
  output logic [7:0]      mode_o,
  output logic [7:0]      status_o,
  output logic [7:0]      outport_o,
  output logic            xlat_en_o,
  output logic            a20_o,
  output logic            sys_rst_o,
  output logic            bad_cmd_o
);
  kbc_dec_t  dec;
  kbc_pw_e   pend_q;
  kbc_byte_t mode_q, stat_q, port_w;
  logic      cmd_go, dat_go;

  assign cmd_go = cmd_wr_i;
  assign dat_go = dat_wr_i && !cmd_wr_i;

  kbc_cmd_decode u_dec (
    .cmd_i (cmd_byte_i),
    .dec_o (dec)
  );

  kbc_outport #(.RST_VAL(PORT_RST)) u_port (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (dat_go && pend_q == PW_PORT),
    .wr_val_i    (dat_byte_i),
    .a20_set_i   (cmd_go && dec.op == OP_A20_ON),
    .a20_clr_i   (cmd_go && dec.op == OP_A20_OFF),
    .pulse_rst_i (cmd_go && dec.op == OP_SYSRST),
    .port_o      (port_w),
    .a20_o       (a20_o),
    .sys_rst_o   (sys_rst_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q        <= MODE_RST;
      stat_q        <= STAT_RST;
      pend_q        <= PW_NONE;
      rep_vld_o     <= 1'b0;
      rep_byte_o    <= '0;
      rep_aux_o     <= 1'b0;
      kbd_tx_vld_o  <= 1'b0;
      kbd_tx_byte_o <= '0;
      aux_tx_vld_o  <= 1'b0;
      aux_tx_byte_o <= '0;
      bad_cmd_o     <= 1'b0;
    end else begin
      rep_vld_o    <= 1'b0;
      kbd_tx_vld_o <= 1'b0;
      aux_tx_vld_o <= 1'b0;
      bad_cmd_o    <= 1'b0;
      if (cmd_go) begin
        case (dec.op)
          OP_BAD:     bad_cmd_o <= 1'b1;
          OP_RD_MODE: begin rep_vld_o <= 1'b1; rep_byte_o <= mode_q; rep_aux_o <= 1'b0; end
          OP_RD_PORT: begin rep_vld_o <= 1'b1; rep_byte_o <= port_w; rep_aux_o <= 1'b0; end
          OP_REPLY_K: begin rep_vld_o <= 1'b1; rep_byte_o <= dec.konst; rep_aux_o <= 1'b0; end
          OP_SELFTEST: begin
            stat_q[STAT_SELFTEST] <= 1'b1;
            rep_vld_o  <= 1'b1;
            rep_byte_o <= dec.konst;
            rep_aux_o  <= 1'b0;
          end
          OP_ARM:     pend_q <= dec.arm;
          OP_KBD_OFF: mode_q[MODE_KBD_OFF] <= 1'b1;
          OP_KBD_ON:  mode_q[MODE_KBD_OFF] <= 1'b0;
          OP_AUX_OFF: mode_q[MODE_AUX_OFF] <= 1'b1;
          OP_AUX_ON:  mode_q[MODE_AUX_OFF] <= 1'b0;
          default: ;
        endcase
      end else if (dat_go) begin
        pend_q <= PW_NONE;
        case (pend_q)
          PW_NONE: begin
            kbd_tx_vld_o  <= 1'b1;
            kbd_tx_byte_o <= dat_byte_i;
            mode_q[MODE_KBD_OFF] <= 1'b0;
          end
          PW_AUX: begin
            aux_tx_vld_o  <= 1'b1;
            aux_tx_byte_o <= dat_byte_i;
            mode_q[MODE_AUX_OFF] <= 1'b0;
          end
          PW_MODE: mode_q <= dat_byte_i;
          PW_KREP: begin rep_vld_o <= 1'b1; rep_byte_o <= dat_byte_i; rep_aux_o <= 1'b0; end
          PW_AREP: begin rep_vld_o <= 1'b1; rep_byte_o <= dat_byte_i; rep_aux_o <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  assign mode_o    = mode_q;
  assign status_o  = stat_q;
  assign outport_o = port_w;
  assign xlat_en_o = mode_q[MODE_XLAT];

  // R12
  bad_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_i && dec.op == OP_BAD) |=>
      (bad_cmd_o && $stable(mode_q) && $stable(stat_q) && $stable(pend_q) && $stable(port_w)));
  // R3
  selftest_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr_i && dec.op == OP_SELFTEST) |=>
      (stat_q[STAT_SELFTEST] && rep_vld_o && rep_byte_o == 8'h55));
  // R6
  kbd_route_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr_i && !cmd_wr_i && pend_q == PW_NONE) |=>
      (kbd_tx_vld_o && !mode_q[MODE_KBD_OFF] && kbd_tx_byte_o == $past(dat_byte_i)));
  // R5
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (dat_wr_i && !cmd_wr_i) |=> (pend_q == PW_NONE));
  // R13
  one_sink_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rep_vld_o, kbd_tx_vld_o, aux_tx_vld_o}));
endmodule

// File: tb/kbc_cmd_engine_tb.sv
`timescale 1ns/1ps
module kbc_cmd_engine_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0, dat_wr = 1'b0;
  logic [7:0] cmd_byte = '0, dat_byte = '0;
  logic rep_vld, rep_aux, ktx_vld, atx_vld, xlat, a20, srst, bad;
  logic [7:0] rep_byte, ktx_byte, atx_byte, mode, status, outport;

  int total = 0;
  int errs  = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  kbc_cmd_engine dut_i (
    .clk(clk), .rst(rst),
    .cmd_wr_i(cmd_wr), .cmd_byte_i(cmd_byte),
    .dat_wr_i(dat_wr), .dat_byte_i(dat_byte),
    .rep_vld_o(rep_vld), .rep_byte_o(rep_byte), .rep_aux_o(rep_aux),
    .kbd_tx_vld_o(ktx_vld), .kbd_tx_byte_o(ktx_byte),
    .aux_tx_vld_o(atx_vld), .aux_tx_byte_o(atx_byte),
    .mode_o(mode), .status_o(status), .outport_o(outport),
    .xlat_en_o(xlat), .a20_o(a20), .sys_rst_o(srst), .bad_cmd_o(bad)
  );

  // reference model state
  logic [7:0] m_mode, m_stat, m_port, m_pend;
  logic [7:0] m_rep_b, m_ktx_b, m_atx_b;
  logic m_rep_v, m_rep_a, m_ktx_v, m_atx_v, m_srst, m_bad;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 8'h03; m_stat = 8'h18; m_port = 8'hCF; m_pend = 8'h00;
      m_rep_b = 0; m_ktx_b = 0; m_atx_b = 0;
      m_rep_v = 0; m_rep_a = 0; m_ktx_v = 0; m_atx_v = 0; m_srst = 0; m_bad = 0;
    end else begin
      m_rep_v = 0; m_ktx_v = 0; m_atx_v = 0; m_srst = 0; m_bad = 0;
      if (cmd_wr) begin
        if (cmd_byte[7:4] == 4'hF) m_srst = !cmd_byte[0];
        else case (cmd_byte)
          8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4: m_pend = cmd_byte;
          8'h20: begin m_rep_v = 1; m_rep_b = m_mode; m_rep_a = 0; end
          8'hD0: begin m_rep_v = 1; m_rep_b = m_port; m_rep_a = 0; end
          8'hC0: begin m_rep_v = 1; m_rep_b = 8'h80; m_rep_a = 0; end
          8'hA9, 8'hAB: begin m_rep_v = 1; m_rep_b = 8'h00; m_rep_a = 0; end
          8'hAA: begin m_stat = m_stat | 8'h04; m_rep_v = 1; m_rep_b = 8'h55; m_rep_a = 0; end
          8'hAD: m_mode = m_mode | 8'h10;
          8'hAE: m_mode = m_mode & 8'hEF;
          8'hA7: m_mode = m_mode | 8'h20;
          8'hA8: m_mode = m_mode & 8'hDF;
          8'hDD: m_port = m_port & 8'hFD;
          8'hDF: m_port = m_port | 8'h02;
          default: m_bad = 1;
        endcase
      end else if (dat_wr) begin
        case (m_pend)
          8'h00: begin m_ktx_v = 1; m_ktx_b = dat_byte; m_mode = m_mode & 8'hEF; end
          8'hD4: begin m_atx_v = 1; m_atx_b = dat_byte; m_mode = m_mode & 8'hDF; end
          8'h60: m_mode = dat_byte;
          8'hD1: begin m_port = dat_byte; m_srst = !dat_byte[0]; end
          8'hD2: begin m_rep_v = 1; m_rep_b = dat_byte; m_rep_a = 0; end
          8'hD3: begin m_rep_v = 1; m_rep_b = dat_byte; m_rep_a = 1; end
          default: ;
        endcase
        m_pend = 8'h00;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 rep_vld", {7'd0, rep_vld}, {7'd0, m_rep_v});
      chk("R2 rep_byte", rep_byte, m_rep_b);
      chk("R8 rep_aux", {7'd0, rep_aux}, {7'd0, m_rep_a});
      chk("R6 kbd_vld", {7'd0, ktx_vld}, {7'd0, m_ktx_v});
      chk("R6 kbd_byte", ktx_byte, m_ktx_b);
      chk("R6 aux_vld", {7'd0, atx_vld}, {7'd0, m_atx_v});
      chk("R6 aux_byte", atx_byte, m_atx_b);
      chk("R4 mode", mode, m_mode);
      chk("R3 status", status, m_stat);
      chk("R9 outport", outport, m_port);
      chk("R7 xlat", {7'd0, xlat}, {7'd0, m_mode[6]});
      chk("R10 a20", {7'd0, a20}, {7'd0, m_port[1]});
      chk("R11 sys_rst", {7'd0, srst}, {7'd0, m_srst});
      chk("R12 bad", {7'd0, bad}, {7'd0, m_bad});
    end
  end

  // called at a negedge; returns at the next negedge with the result visible
  task automatic wcmd(input logic [7:0] b);
    cmd_wr = 1; cmd_byte = b;
    @(negedge clk);
    cmd_wr = 0;
  endtask
  task automatic wdat(input logic [7:0] b);
    dat_wr = 1; dat_byte = b;
    @(negedge clk);
    dat_wr = 0;
  endtask

  localparam logic [7:0] POOL [0:17] = '{8'h20, 8'h60, 8'hD1, 8'hD2, 8'hD3, 8'hD4,
    8'hA7, 8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hAD, 8'hAE, 8'hC0, 8'hD0, 8'hDD, 8'hDF, 8'hF5};

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; errs++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 8'h03);
    chk("R1 status", status, 8'h18);
    chk("R1 outport", outport, 8'hCF);
    chk("R1 pins", {4'd0, a20, xlat, srst, bad}, 8'h08);
    chk("R1 strobes", {5'd0, rep_vld, ktx_vld, atx_vld}, 8'h00);

    wcmd(8'h20); chk("R2 read mode", {rep_vld, rep_byte[6:0]}, 8'h83);
    wcmd(8'hD0); chk("R2 read port", rep_byte, 8'hCF);
    wcmd(8'hC0); chk("R2 input port", rep_byte, 8'h80);
    wcmd(8'hAB); chk("R2 test reply", {rep_vld, rep_byte[6:0]}, 8'h80);
    wcmd(8'hAA); chk("R3 status", status, 8'h1C); chk("R3 reply", rep_byte, 8'h55);

    wcmd(8'hAD); chk("R4 kbd off", mode, 8'h13);
    wcmd(8'hA7); chk("R4 aux off", mode, 8'h33);
    wdat(8'h5A); chk("R6 kbd byte", ktx_byte, 8'h5A); chk("R6 kbd re-enable", mode, 8'h23);
    wcmd(8'hD4); wdat(8'hF3);
    chk("R6 aux byte", {atx_vld, 7'd0}, 8'h80); chk("R6 aux re-enable", mode, 8'h03);

    wcmd(8'h60); wdat(8'h47);
    chk("R7 mode write", mode, 8'h47); chk("R7 xlat", {7'd0, xlat}, 8'h01);
    wdat(8'h11); chk("R5 disarmed", {ktx_vld, 7'd0}, 8'h80);

    wcmd(8'hD2); wdat(8'hAB); chk("R8 kbd reply", {rep_aux, rep_byte[6:0]}, 8'h2B);
    wcmd(8'hD3); wdat(8'hCD); chk("R8 aux reply", {rep_aux, rep_byte[6:0]}, 8'hCD);

    wcmd(8'hD2); wcmd(8'hA8); wdat(8'h77);
    chk("R5 arm kept", {rep_vld, rep_byte[6:0]}, 8'hF7);
    wcmd(8'h60); wcmd(8'hD3); wdat(8'h01);
    chk("R5 arm replaced", {rep_aux, rep_byte[6:0]}, 8'h81);
    chk("R5 mode kept", mode, 8'h47);

    wcmd(8'hDD); chk("R10 a20 off", outport, 8'hCD); chk("R10 pin", {7'd0, a20}, 8'h00);
    wcmd(8'hDF); chk("R10 a20 on", outport, 8'hCF);

    wcmd(8'hD1); wdat(8'h8C);
    chk("R9 port", outport, 8'h8C); chk("R9 pulse", {srst, a20, 6'd0}, 8'h80);
    @(negedge clk);
    chk("R9 pulse width", {7'd0, srst}, 8'h00);
    chk("R9 no self reset", outport, 8'h8C); chk("R9 mode", mode, 8'h47);
    wcmd(8'hD1); wdat(8'hCF); chk("R9 restore", {srst, 7'd0}, 8'h00);

    wcmd(8'hFE); chk("R11 reset pulse", {7'd0, srst}, 8'h01);
    wcmd(8'hF1); chk("R11 no-op", {srst, bad, 6'd0}, 8'h00); chk("R11 port", outport, 8'hCF);
    wcmd(8'hF0); chk("R11 pulse F0", {7'd0, srst}, 8'h01);

    wcmd(8'hD2); wcmd(8'h33);
    chk("R12 flag", {7'd0, bad}, 8'h01); chk("R12 mode", mode, 8'h47);
    wdat(8'h99); chk("R12 arm kept", {rep_vld, rep_byte[6:0]}, 8'h99);

    cmd_wr = 1; cmd_byte = 8'h20; dat_wr = 1; dat_byte = 8'h5A;
    @(negedge clk);
    cmd_wr = 0; dat_wr = 0;
    chk("R13 cmd wins", rep_byte, 8'h47); chk("R13 data dropped", {7'd0, ktx_vld}, 8'h00);

    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 5;
      case (r)
        0: wcmd(8'($urandom));
        1: wcmd(POOL[$urandom % 18]);
        2: wdat(8'($urandom));
        3: begin
          cmd_wr = 1; cmd_byte = POOL[$urandom % 18]; dat_wr = 1; dat_byte = 8'($urandom);
          @(negedge clk);
          cmd_wr = 0; dat_wr = 0;
        end
        default: @(negedge clk);
      endcase
    end
    @(negedge clk);
    finish_up();
  end
endmodule